// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle it sees the current accumulator, an operand byte and a 4-bit operation code. The operand may come from a register, from memory or from an immediate field; it reaches the block already fetched. The current carry flag is held inside the block. When the execute strobe is high on a rising clock edge, the block writes the new accumulator value and the new flag bits into its own registers. When the strobe is low, both registers keep their values.

Five flags are kept: sign, zero, half carry (the carry or borrow between the two nibbles), parity and carry. Each operation has its own rule for which flags it writes. Flags that an operation does not write keep their old values.

The operation set covers:
- addition and subtraction, each with and without the incoming carry or borrow;
- bitwise AND, XOR and OR;
- a compare that leaves the accumulator untouched;
- four single-bit rotates;
- a decimal adjust that corrects the sum of two packed BCD bytes.

The operand is not used by the rotates, the decimal adjust or the reserved codes. The only way to load the accumulator is through an operation. For example, after reset, OR with the wanted byte loads that byte.

Top module: `acc_alu_core`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the accumulator and all five flags. Reset wins over an asserted execute strobe.
- R2: The accumulator and the flags change only on a rising edge where exec_en is high. With exec_en low they hold, whatever the opcode and operand.
- R3: Opcode 0 (add) and opcode 1 (add with carry) write A+B (opcode 1 adds A+B+CY) to the accumulator. CY is the carry out of bit 7. The half flag is the carry out of bit 3.
- R4: Opcode 2 (subtract) and opcode 3 (subtract with borrow) write A-B (opcode 3 writes A-B-CY). CY is set when B plus the borrow-in exceeds A as unsigned values. The half flag is the borrow out of bit 3.
- R5: Every opcode that writes sign, zero and parity (0-7 and 12) sets them from its 8-bit result. Sign is bit 7. Zero is set when the result is 0x00. Parity is set when the result has an even number of one bits.
- R6: Opcode 4 (AND) writes A&B, clears CY and sets the half flag.
- R7: Opcode 5 (XOR) and opcode 6 (OR) write A^B or A|B and clear both CY and the half flag.
- R8: Opcode 7 (compare) leaves the accumulator unchanged and sets all five flags as a subtract A-B would. As a result, CY is set when A<B, zero is set when A=B, and both are clear when A>B.
- R9: Opcode 8 rotates the accumulator left, with bit 7 going to bit 0 and to CY. Opcode 9 rotates it right, with bit 0 going to bit 7 and to CY.
- R10: Opcode 10 rotates left through carry: bit 7 goes to CY and the old CY goes to bit 0. Opcode 11 rotates right through carry: bit 0 goes to CY and the old CY goes to bit 7.
- R11: The rotates (opcodes 8-11) leave the sign, zero, parity and half flags unchanged.
- R12: Opcode 12 (decimal adjust) works in two steps. First it adds 6 when the low nibble is above 9 or the half flag is set. Then it adds 0x60 when the high nibble of that intermediate value is above 9, or CY is set, or the first step overflowed. CY becomes 1 exactly when the second step is applied. The half flag is the carry out of bit 3 of the first step.
- R13: Opcodes 13, 14 and 15 change neither the accumulator nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute strobe; the registers load only when it is high |
| op_code | input | 4 | Operation select (encodings in R3-R13) |
| operand | input | DATA_W | Second source byte |
| acc_q | output | DATA_W | Accumulator register |
| flg_sign | output | 1 | Sign flag |
| flg_zero | output | 1 | Zero flag |
| flg_half | output | 1 | Half carry / nibble borrow flag |
| flg_par | output | 1 | Even parity flag |
| flg_carry | output | 1 | Carry / borrow flag |

## Verification
Each result is due one rising edge after the stimulus. Inputs are applied on a falling edge, the registers capture them on the next rising edge, and the accumulator and flags can be read straight after that edge. The driver applies one stimulus per falling edge and pushes the expected accumulator and flags for that cycle, including idle cycles, whose expected value is the unchanged state. The monitor pops one item shortly after each rising edge, so every comparison lines up with exactly one register update. Reset is checked on the falling edge after the capturing rising edge.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADC  = 4'd1,
      OP_SUB  = 4'd2,
      OP_SBB  = 4'd3,
      OP_AND  = 4'd4,
      OP_XOR  = 4'd5,
      OP_OR   = 4'd6,
      OP_CMP  = 4'd7,
      OP_ROLC = 4'd8,
      OP_RORC = 4'd9,
      OP_ROLT = 4'd10,
      OP_RORT = 4'd11,
      OP_DADJ = 4'd12
   } alu_op_e;

   typedef struct packed {
      logic s;
      logic z;
      logic ac;
      logic p;
      logic cy;
   } flag_t;

   localparam int OP_W = 4;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   input  logic              sub,
   output logic [DATA_W-1:0] res,
   output logic              cy_out,
   output logic              ac_out
);
   localparam int HALF_BIT = 4;

   logic [DATA_W:0] wide;
   logic [DATA_W:0] ext_a;
   logic [DATA_W:0] ext_b;
   logic [DATA_W:0] ext_c;

   assign ext_a = {1'b0, a};
   assign ext_b = {1'b0, b};
   assign ext_c = {{DATA_W{1'b0}}, cin};

   always_comb begin
      if (sub) wide = ext_a - ext_b - ext_c;
      else     wide = ext_a + ext_b + ext_c;
   end

   assign res    = wide[DATA_W-1:0];
   assign cy_out = wide[DATA_W];
   // carry (or borrow) into bit 4 recovered from the three bit-4 values
   assign ac_out = a[HALF_BIT] ^ b[HALF_BIT] ^ wide[HALF_BIT];

endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   input  logic [1:0]        sel,
   output logic [DATA_W-1:0] bw_res,
   output logic [DATA_W-1:0] rot_res,
   output logic              rot_cy
);
   localparam int MSB = DATA_W - 1;

   always_comb begin
      unique case (sel)
         2'b00:   bw_res = a & b;
         2'b01:   bw_res = a ^ b;
         2'b10:   bw_res = a | b;
         default: bw_res = b;
      endcase
   end

   always_comb begin
      unique case (sel)
         2'b00: begin
            rot_res = {a[MSB-1:0], a[MSB]};
            rot_cy  = a[MSB];
         end
         2'b01: begin
            rot_res = {a[0], a[MSB:1]};
            rot_cy  = a[0];
         end
         2'b10: begin
            rot_res = {a[MSB-1:0], cin};
            rot_cy  = a[MSB];
         end
         default: begin
            rot_res = {cin, a[MSB:1]};
            rot_cy  = a[0];
         end
      endcase
   end

endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic              ac_in,
   input  logic              cy_in,
   output logic [DATA_W-1:0] res,
   output logic              ac_out,
   output logic              cy_out
);
   localparam int          NIB    = DATA_W / 2;
   localparam logic [NIB-1:0] DIG_MAX = NIB'(9);
   localparam logic [DATA_W:0] LO_FIX = (DATA_W+1)'(6);
   localparam logic [DATA_W-1:0] HI_FIX = DATA_W'(6) << NIB;

   logic              lo_go;
   logic              hi_go;
   logic [DATA_W:0]   step1;

   always_comb begin
      lo_go  = (a[NIB-1:0] > DIG_MAX) || ac_in;
      step1  = {1'b0, a} + (lo_go ? LO_FIX : '0);
      hi_go  = (step1[DATA_W-1:NIB] > DIG_MAX) || cy_in || step1[DATA_W];
      res    = step1[DATA_W-1:0] + (hi_go ? HI_FIX : '0);
      cy_out = hi_go;
      ac_out = a[NIB] ^ step1[NIB];
   end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter bit DEC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              exec_en,
   input  logic [OP_W-1:0]   op_code,
   input  logic [DATA_W-1:0] operand,
   output logic [DATA_W-1:0] acc_q,
   output logic              flg_sign,
   output logic              flg_zero,
   output logic              flg_half,
   output logic              flg_par,
   output logic              flg_carry
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W < 8) begin : g_chk_w
      $error("acc_alu_core: DATA_W must be at least 8");
   end
   if (DEC_EN && DATA_W != 8) begin : g_chk_dec
      $error("acc_alu_core: decimal adjust needs DATA_W == 8");
   end

   flag_t             flags_q;
   flag_t             flags_d;
   logic [DATA_W-1:0] acc_d;

   logic              is_sub;
   logic              use_cin;
   logic [DATA_W-1:0] as_res;
   logic              as_cy;
   logic              as_ac;
   logic [DATA_W-1:0] bw_res;
   logic [DATA_W-1:0] rot_res;
   logic              rot_cy;
   logic [DATA_W-1:0] dec_res;
   logic              dec_cy;
   logic              dec_ac;

   assign is_sub  = (op_code == OP_SUB) || (op_code == OP_SBB) || (op_code == OP_CMP);
   assign use_cin = (op_code == OP_ADC) || (op_code == OP_SBB);

   acc_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a      (acc_q),
      .b      (operand),
      .cin    (use_cin & flags_q.cy),
      .sub    (is_sub),
      .res    (as_res),
      .cy_out (as_cy),
      .ac_out (as_ac)
   );

   acc_alu_bitops #(.DATA_W(DATA_W)) u_bitops (
      .a       (acc_q),
      .b       (operand),
      .cin     (flags_q.cy),
      .sel     (op_code[1:0]),
      .bw_res  (bw_res),
      .rot_res (rot_res),
      .rot_cy  (rot_cy)
   );

   if (DEC_EN) begin : g_dec
      acc_alu_decadj #(.DATA_W(DATA_W)) u_decadj (
         .a      (acc_q),
         .ac_in  (flags_q.ac),
         .cy_in  (flags_q.cy),
         .res    (dec_res),
         .ac_out (dec_ac),
         .cy_out (dec_cy)
      );
   end else begin : g_nodec
      assign dec_res = acc_q;
      assign dec_ac  = flags_q.ac;
      assign dec_cy  = flags_q.cy;
   end

   logic              szp_en;
   logic [DATA_W-1:0] szp_src;

   always_comb begin
      acc_d   = acc_q;
      flags_d = flags_q;
      szp_en  = 1'b0;
      szp_src = acc_q;
      case (op_code)
         OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
            acc_d      = as_res;
            flags_d.cy = as_cy;
            flags_d.ac = as_ac;
            szp_en     = 1'b1;
            szp_src    = as_res;
         end
         OP_CMP: begin
            flags_d.cy = as_cy;
            flags_d.ac = as_ac;
            szp_en     = 1'b1;
            szp_src    = as_res;
         end
         OP_AND, OP_XOR, OP_OR: begin
            acc_d      = bw_res;
            flags_d.cy = 1'b0;
            flags_d.ac = (op_code == OP_AND);
            szp_en     = 1'b1;
            szp_src    = bw_res;
         end
         OP_ROLC, OP_RORC, OP_ROLT, OP_RORT: begin
            acc_d      = rot_res;
            flags_d.cy = rot_cy;
         end
         OP_DADJ: begin
            acc_d      = dec_res;
            flags_d.cy = dec_cy;
            flags_d.ac = dec_ac;
            szp_en     = 1'b1;
            szp_src    = dec_res;
         end
         default: ;
      endcase
      if (szp_en) begin
         flags_d.s = szp_src[MSB];
         flags_d.z = (szp_src == '0);
         flags_d.p = ~(^szp_src);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q   <= '0;
         flags_q <= '0;
      end else if (exec_en) begin
         acc_q   <= acc_d;
         flags_q <= flags_d;
      end
   end

   assign flg_sign  = flags_q.s;
   assign flg_zero  = flags_q.z;
   assign flg_half  = flags_q.ac;
   assign flg_par   = flags_q.p;
   assign flg_carry = flags_q.cy;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              exec_en,
   input logic [OP_W-1:0]   op_code,
   input logic [DATA_W-1:0] acc_q,
   input logic              flg_sign,
   input logic              flg_zero,
   input logic              flg_half,
   input logic              flg_par,
   input logic              flg_carry
);
   logic [4:0] fl;
   logic       rot_op;
   logic       szp_op;

   assign fl     = {flg_sign, flg_zero, flg_half, flg_par, flg_carry};
   assign rot_op = (op_code >= OP_ROLC) && (op_code <= OP_RORT);
   assign szp_op = (op_code <= OP_OR) || (op_code == OP_DADJ);

   // R2
   hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !exec_en |=> ($stable(acc_q) && $stable(fl)));

   // R5
   szp_match_chk: assert property (@(posedge clk) disable iff (rst)
      (exec_en && szp_op) |=>
         (flg_zero == (acc_q == '0)) && (flg_sign == acc_q[DATA_W-1]) && (flg_par == ~(^acc_q)));

   // R6
   and_flags_chk: assert property (@(posedge clk) disable iff (rst)
      (exec_en && op_code == OP_AND) |=> (flg_half && !flg_carry));

   // R7
   orx_flags_chk: assert property (@(posedge clk) disable iff (rst)
      (exec_en && (op_code == OP_OR || op_code == OP_XOR)) |=> (!flg_half && !flg_carry));

   // R8
   cmp_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (exec_en && op_code == OP_CMP) |=> $stable(acc_q));

   // R10
   rolt_path_chk: assert property (@(posedge clk) disable iff (rst)
      (exec_en && op_code == OP_ROLT) |=>
         (acc_q[0] == $past(flg_carry)) && (flg_carry == $past(acc_q[DATA_W-1])));

   // R11
   rot_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (exec_en && rot_op) |=>
         ($stable(flg_sign) && $stable(flg_zero) && $stable(flg_par) && $stable(flg_half)));

   // R13
   rsv_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (exec_en && op_code > OP_DADJ) |=> ($stable(acc_q) && $stable(fl)));

endmodule

bind acc_alu_core acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .exec_en   (exec_en),
   .op_code   (op_code),
   .acc_q     (acc_q),
   .flg_sign  (flg_sign),
   .flg_zero  (flg_zero),
   .flg_half  (flg_half),
   .flg_par   (flg_par),
   .flg_carry (flg_carry)
);

// File: tb/acc_alu_core_tb_top.sv
module acc_alu_core_tb_top;
   import acc_alu_pkg::*;

   logic       clk = 1'b0;
   logic       rst;
   logic       exec_en;
   logic [3:0] op_code;
   logic [7:0] operand;
   logic [7:0] acc_q;
   logic       flg_sign, flg_zero, flg_half, flg_par, flg_carry;

   always #5 clk = ~clk;

   acc_alu_core dut_i (
      .clk       (clk),
      .rst       (rst),
      .exec_en   (exec_en),
      .op_code   (op_code),
      .operand   (operand),
      .acc_q     (acc_q),
      .flg_sign  (flg_sign),
      .flg_zero  (flg_zero),
      .flg_half  (flg_half),
      .flg_par   (flg_par),
      .flg_carry (flg_carry)
   );

   typedef struct {
      string      tag;
      logic [7:0] acc;
      logic [4:0] fl;
   } item_t;

   item_t      exp_q[$];
   int         n_chk  = 0;
   int         n_fail = 0;
   logic [7:0] m_acc  = 8'h00;
   logic [4:0] m_fl   = 5'b0;   // {s, z, ac, p, cy}

   function automatic logic [2:0] szp_of(input int v);
      logic [7:0] b;
      b = v[7:0];
      return {b[7], (b == 8'h00), ~(^b)};
   endfunction

   task automatic model_step(input logic [3:0] op, input logic [7:0] opnd);
      int a, b, c, r, ci, lo_add;
      logic [2:0] szp;
      logic lo_go, hi_go;
      a = int'(m_acc); b = int'(opnd); c = int'(m_fl[0]);
      case (op)
         4'd0, 4'd1: begin
            ci = (op == 4'd1) ? c : 0;
            r = a + b + ci;
            szp = szp_of(r);
            m_fl = {szp[2], szp[1], (((a & 15) + (b & 15) + ci) > 15), szp[0], (r > 255)};
            m_acc = r[7:0];
         end
         4'd2, 4'd3, 4'd7: begin
            ci = (op == 4'd3) ? c : 0;
            r = a - b - ci;
            szp = szp_of(r & 255);
            m_fl = {szp[2], szp[1], (((b & 15) + ci) > (a & 15)), szp[0], ((b + ci) > a)};
            if (op != 4'd7) m_acc = r[7:0];
         end
         4'd4, 4'd5, 4'd6: begin
            r = (op == 4'd4) ? (a & b) : (op == 4'd5) ? (a ^ b) : (a | b);
            szp = szp_of(r);
            m_fl = {szp[2], szp[1], (op == 4'd4), szp[0], 1'b0};
            m_acc = r[7:0];
         end
         4'd8:  begin r = ((a << 1) | (a >> 7)) & 255; m_fl[0] = a[7]; m_acc = r[7:0]; end
         4'd9:  begin r = (a >> 1) | ((a & 1) << 7);   m_fl[0] = a[0]; m_acc = r[7:0]; end
         4'd10: begin r = ((a << 1) | c) & 255;        m_fl[0] = a[7]; m_acc = r[7:0]; end
         4'd11: begin r = (a >> 1) | (c << 7);         m_fl[0] = a[0]; m_acc = r[7:0]; end
         4'd12: begin
            lo_go  = ((a & 15) > 9) || m_fl[2];
            lo_add = lo_go ? 6 : 0;
            r      = a + lo_add;
            hi_go  = (((r >> 4) & 15) > 9) || m_fl[0] || (r > 255);
            m_fl[2] = ((a & 15) + lo_add) > 15;
            r = (r + (hi_go ? 96 : 0)) & 255;
            szp = szp_of(r);
            m_fl = {szp[2], szp[1], m_fl[2], szp[0], hi_go};
            m_acc = r[7:0];
         end
         default: ;
      endcase
   endtask

   task automatic drive(input logic en, input logic [3:0] op, input logic [7:0] opnd,
                        input string tag);
      item_t it;
      @(negedge clk);
      exec_en = en;
      op_code = op;
      operand = opnd;
      if (en) model_step(op, opnd);
      it.tag = tag;
      it.acc = m_acc;
      it.fl  = m_fl;
      exp_q.push_back(it);
   endtask

   always @(posedge clk) begin
      item_t it;
      logic [4:0] got;
      #2;
      if (exp_q.size() > 0) begin
         it  = exp_q.pop_front();
         got = {flg_sign, flg_zero, flg_half, flg_par, flg_carry};
         n_chk++;
         if (acc_q !== it.acc || got !== it.fl) begin
            n_fail++;
            $display("FAIL %s: acc=%02h flags=%05b expected acc=%02h flags=%05b",
                     it.tag, acc_q, got, it.acc, it.fl);
         end
      end
   end

   task automatic check_zero_state(input string tag);
      n_chk++;
      if (acc_q !== 8'h00 || {flg_sign, flg_zero, flg_half, flg_par, flg_carry} !== 5'b0) begin
         n_fail++;
         $display("FAIL %s: acc=%02h flags=%05b expected acc=00 flags=00000", tag, acc_q,
                  {flg_sign, flg_zero, flg_half, flg_par, flg_carry});
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
   end

   initial begin
      rst = 1'b1; exec_en = 1'b0; op_code = 4'd0; operand = 8'h00;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check_zero_state("R1");
      rst = 1'b0;

      drive(1'b0, OP_ADD,  8'h55, "R2");
      drive(1'b1, OP_OR,   8'h38, "R7");
      drive(1'b1, OP_ADD,  8'h45, "R3");
      drive(1'b1, OP_DADJ, 8'h00, "R12");
      drive(1'b1, OP_ADD,  8'hFF, "R3");
      drive(1'b1, OP_ADC,  8'h00, "R3");
      drive(1'b1, OP_SUB,  8'h90, "R4");
      drive(1'b1, OP_SBB,  8'h01, "R4");
      drive(1'b1, OP_SBB,  8'h0F, "R4");
      drive(1'b1, OP_CMP,  m_acc, "R8");
      drive(1'b1, OP_CMP,  8'hFF, "R8");
      drive(1'b1, OP_CMP,  8'h00, "R8");
      drive(1'b1, OP_AND,  8'h0F, "R6");
      drive(1'b1, OP_XOR,  m_acc, "R7");
      drive(1'b1, OP_OR,   8'h81, "R5");
      drive(1'b1, OP_ROLC, 8'h00, "R9");
      drive(1'b1, OP_RORC, 8'h00, "R9");
      drive(1'b1, OP_RORC, 8'h00, "R11");
      drive(1'b1, OP_ADD,  8'hF0, "R3");
      drive(1'b1, OP_ROLT, 8'h00, "R10");
      drive(1'b1, OP_RORT, 8'h00, "R10");
      drive(1'b1, OP_RORT, 8'h00, "R11");
      drive(1'b1, OP_XOR,  m_acc, "R7");
      drive(1'b1, OP_OR,   8'h99, "R7");
      drive(1'b1, OP_ADD,  8'h99, "R3");
      drive(1'b1, OP_DADJ, 8'h00, "R12");
      drive(1'b1, OP_AND,  8'h00, "R6");
      drive(1'b1, OP_OR,   8'h9A, "R7");
      drive(1'b1, OP_DADJ, 8'h00, "R12");
      drive(1'b1, 4'd13,   8'h77, "R13");
      drive(1'b1, 4'd14,   8'h00, "R13");
      drive(1'b1, 4'd15,   8'hFF, "R13");
      drive(1'b0, OP_CMP,  8'hFF, "R2");
      drive(1'b0, OP_ROLT, 8'h00, "R2");

      @(negedge clk);
      rst = 1'b1; exec_en = 1'b1; op_code = OP_OR; operand = 8'hFF;
      @(negedge clk);
      check_zero_state("R1");
      rst = 1'b0; exec_en = 1'b0;
      m_acc = 8'h00; m_fl = 5'b0;
      drive(1'b1, OP_ADC, 8'h01, "R3");

      while (exp_q.size() > 0) @(negedge clk);
      @(negedge clk);
      finish_run();
   end

endmodule